// File: doc/BRIEF.md
# Background Page Clearing Engine

This block sits next to a memory controller and wipes freed memory pages while the controller has nothing else to do. Software hands it ranges of freed pages, each given as a page-aligned base address and a page count, and these wait in an internal request list. Whenever the controller raises its idle indication, the engine presents 64-byte zero writes marked as non-cacheable, one line at a time, and walks each range in ascending address order.

Each page is reported back to software as soon as its last line is accepted: the page base address goes into a completion queue that software reads and pops. The page size is chosen per request from four sizes: 4 KiB, 16 KiB, 64 KiB and 256 KiB. A busy output tells software whether any work is still waiting or under way.

Top module: `zero_sweeper`

## Requirements
- R1: After synchronous reset, wr_valid, done_valid, busy, push_ok, push_rej_full and push_rej_bad are all low.
- R2: Every push gets exactly one response pulse in the following cycle. A push whose base is aligned to the selected page size and whose page count is nonzero, made while the list has room, gives push_ok. The page size is 4096 << (2*push_size) bytes, so push_size 0, 1, 2 and 3 select 4, 16, 64 and 256 KiB.
- R3: A push with a misaligned base or a zero page count gives push_rej_bad, even when the list is full, and is never written. A cycle with no push gives no response.
- R4: The request list holds 8 queued ranges plus the one being cleared. If the engine cannot issue, ten back-to-back pushes give nine push_ok and one push_rej_full.
- R5: wr_valid rises only after a clock edge at which mc_idle was high. No new write appears while mc_idle is low.
- R6: A presented write keeps wr_valid high and wr_addr unchanged until wr_ready accepts it, even if mc_idle falls.
- R7: Accepted write addresses cover every page of a range in ascending 64-byte steps, from base to base + pages*size - 64. Ranges are served in the order they were accepted, each with the page size latched at push time.
- R8: After the last line of a page is accepted, that page's base address enters the completion queue. done_valid and done_addr show the oldest entry, and done_pop removes it. Pages appear in the order they were cleared.
- R9: While the completion queue holds 8 unread entries, no new write is presented.
- R10: busy is high exactly while an accepted range is queued or not yet fully cleared.
- R11: Every presented write carries all-zero data with wr_nocache high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Request to add a freed range |
| push_base | input | 32 | Range base address |
| push_pages | input | 8 | Number of pages in the range |
| push_size | input | 2 | Page size select for the range |
| push_ok | output | 1 | Push accepted (one cycle after push) |
| push_rej_full | output | 1 | Push refused, request list full |
| push_rej_bad | output | 1 | Push refused, misaligned base or zero count |
| mc_idle | input | 1 | Memory controller has a free slot |
| wr_valid | output | 1 | Zero write presented |
| wr_addr | output | 32 | Line address of the write |
| wr_data | output | 512 | Write data, always zero |
| wr_nocache | output | 1 | Write bypasses caches |
| wr_ready | input | 1 | Controller accepts the write |
| done_valid | output | 1 | Completion queue not empty |
| done_addr | output | 32 | Base of the oldest cleared page |
| done_pop | input | 1 | Remove the oldest completion |
| busy | output | 1 | Work queued or in progress |

## Verification
A corrupted line counter or page base shows up on the very next accepted write as an address outside the expected ascending sequence. A bad page count shows when the wrong number of completions arrive before the range ends. A lost or duplicated completion shows on done_addr as soon as software reaches that entry. A wrong occupancy in either queue shows within one cycle: as a wrong push response, as busy disagreeing with the outstanding work, or as a write rising while eight completions are unread.

// File: rtl/zs_pkg.sv
package zs_pkg;
    localparam int ZS_ADDR_W     = 32;
    localparam int ZS_CNT_W      = 8;
    localparam int ZS_SEL_W      = 2;
    localparam int ZS_LINE_SHIFT = 6;
    localparam int ZS_BASE_SHIFT = 12;
    localparam int ZS_MAX_SHIFT  = ZS_BASE_SHIFT + 2 * ((1 << ZS_SEL_W) - 1);
    localparam int ZS_LINE_IDX_W = ZS_MAX_SHIFT - ZS_LINE_SHIFT;

    typedef logic [ZS_SEL_W-1:0] size_sel_t;

    typedef struct packed {
        logic [ZS_ADDR_W-1:0] base;
        logic [ZS_CNT_W-1:0]  pages;
        size_sel_t            sel;
    } range_t;

    function automatic int page_shift(input size_sel_t s);
        return ZS_BASE_SHIFT + 2 * int'(s);
    endfunction

    function automatic logic [ZS_ADDR_W-1:0] page_bytes(input size_sel_t s);
        return ZS_ADDR_W'(1) << page_shift(s);
    endfunction

    function automatic logic [ZS_ADDR_W-1:0] page_mask(input size_sel_t s);
        return page_bytes(s) - ZS_ADDR_W'(1);
    endfunction

    function automatic logic [ZS_LINE_IDX_W-1:0] last_line(input size_sel_t s);
        return (ZS_LINE_IDX_W'(1) << (page_shift(s) - ZS_LINE_SHIFT)) - ZS_LINE_IDX_W'(1);
    endfunction
endpackage

// File: rtl/zs_fifo.sv
module zs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    assign dout  = mem[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
endmodule

// File: rtl/zs_sweep.sv
module zs_sweep
    import zs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rq_empty,
    input  range_t               rq_head,
    output logic                 rq_pop,
    input  logic                 mc_idle,
    input  logic                 wr_ready,
    input  logic                 cq_full,
    output logic                 wr_valid,
    output logic [ZS_ADDR_W-1:0] wr_addr,
    output logic                 cq_push,
    output logic [ZS_ADDR_W-1:0] cq_addr,
    output logic                 active
);
    logic [ZS_ADDR_W-1:0]     page_base;
    logic [ZS_CNT_W-1:0]      pages_left;
    logic [ZS_LINE_IDX_W-1:0] line_idx;
    size_sel_t                sel;
    logic                     accept;
    logic                     end_of_page;

    assign rq_pop      = !active && !rq_empty;
    assign accept      = wr_valid && wr_ready;
    assign end_of_page = (line_idx == last_line(sel));
    assign wr_addr     = page_base + (ZS_ADDR_W'(line_idx) << ZS_LINE_SHIFT);
    assign cq_push     = accept && end_of_page;
    assign cq_addr     = page_base;

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            wr_valid   <= 1'b0;
            page_base  <= '0;
            pages_left <= '0;
            line_idx   <= '0;
            sel        <= '0;
        end else if (rq_pop) begin
            active     <= 1'b1;
            page_base  <= rq_head.base;
            pages_left <= rq_head.pages;
            sel        <= rq_head.sel;
            line_idx   <= '0;
        end else if (accept) begin
            wr_valid <= 1'b0;
            if (end_of_page) begin
                line_idx   <= '0;
                page_base  <= page_base + page_bytes(sel);
                pages_left <= pages_left - 1'b1;
                if (pages_left == ZS_CNT_W'(1)) active <= 1'b0;
            end else begin
                line_idx <= line_idx + 1'b1;
            end
        end else if (active && !wr_valid && mc_idle && !cq_full) begin
            wr_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/zero_sweeper.sv
module zero_sweeper
    import zs_pkg::*;
#(
    parameter int REQ_DEPTH  = 8,
    parameter int DONE_DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_valid,
    input  logic [ZS_ADDR_W-1:0]         push_base,
    input  logic [ZS_CNT_W-1:0]          push_pages,
    input  logic [ZS_SEL_W-1:0]          push_size,
    output logic                         push_ok,
    output logic                         push_rej_full,
    output logic                         push_rej_bad,
    input  logic                         mc_idle,
    output logic                         wr_valid,
    output logic [ZS_ADDR_W-1:0]         wr_addr,
    output logic [(8<<ZS_LINE_SHIFT)-1:0] wr_data,
    output logic                         wr_nocache,
    input  logic                         wr_ready,
    output logic                         done_valid,
    output logic [ZS_ADDR_W-1:0]         done_addr,
    input  logic                         done_pop,
    output logic                         busy
);
    range_t               in_rng, rq_head;
    logic                 rq_full, rq_empty, rq_pop, rq_push, push_bad;
    logic                 cq_push, cq_full, cq_empty;
    logic [ZS_ADDR_W-1:0] cq_addr;
    logic                 sw_active;

    assign in_rng   = '{base: push_base, pages: push_pages, sel: push_size};
    assign push_bad = ((push_base & page_mask(push_size)) != '0) || (push_pages == '0);
    assign rq_push  = push_valid && !push_bad && !rq_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            push_ok       <= 1'b0;
            push_rej_full <= 1'b0;
            push_rej_bad  <= 1'b0;
        end else begin
            push_ok       <= rq_push;
            push_rej_bad  <= push_valid && push_bad;
            push_rej_full <= push_valid && !push_bad && rq_full;
        end
    end

    zs_fifo #(.W($bits(range_t)), .DEPTH(REQ_DEPTH)) u_req (
        .clk(clk), .rst(rst), .push(rq_push), .din(in_rng), .pop(rq_pop),
        .dout(rq_head), .full(rq_full), .empty(rq_empty)
    );

    zs_sweep u_sweep (
        .clk(clk), .rst(rst), .rq_empty(rq_empty), .rq_head(rq_head), .rq_pop(rq_pop),
        .mc_idle(mc_idle), .wr_ready(wr_ready), .cq_full(cq_full),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .cq_push(cq_push),
        .cq_addr(cq_addr), .active(sw_active)
    );

    zs_fifo #(.W(ZS_ADDR_W), .DEPTH(DONE_DEPTH)) u_done (
        .clk(clk), .rst(rst), .push(cq_push), .din(cq_addr),
        .pop(done_pop && !cq_empty), .dout(done_addr),
        .full(cq_full), .empty(cq_empty)
    );

    assign done_valid = !cq_empty;
    assign wr_data    = '0;
    assign wr_nocache = wr_valid;
    assign busy       = !rq_empty || sw_active;
endmodule

// File: rtl/zs_checker.sv
module zs_checker
    import zs_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 push_valid,
    input logic                 push_ok,
    input logic                 push_rej_full,
    input logic                 push_rej_bad,
    input logic                 mc_idle,
    input logic                 wr_valid,
    input logic                 wr_ready,
    input logic [ZS_ADDR_W-1:0] wr_addr,
    input logic                 busy,
    input logic                 cq_full
);
    assert_one_resp_R2: assert property (@(posedge clk) disable iff (rst)
        push_valid |=> $countones({push_ok, push_rej_full, push_rej_bad}) == 1);

    assert_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !push_valid |=> !(push_ok || push_rej_full || push_rej_bad));

    assert_idle_gate_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_valid) |-> $past(mc_idle));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr)));

    assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_valid) |-> !$past(cq_full));

    assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy);
endmodule

bind zero_sweeper zs_checker u_chk (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_ok(push_ok),
    .push_rej_full(push_rej_full), .push_rej_bad(push_rej_bad),
    .mc_idle(mc_idle), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .busy(busy), .cq_full(cq_full)
);

// File: tb/zero_sweeper_test.sv
module zero_sweeper_test;
    import zs_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1;
    logic        push_valid = 1'b0;
    logic [31:0] push_base = '0;
    logic [7:0]  push_pages = '0;
    logic [1:0]  push_size = '0;
    logic        push_ok, push_rej_full, push_rej_bad;
    logic        mc_idle, wr_ready, done_pop;
    logic        wr_valid, wr_nocache, done_valid, busy;
    logic [31:0] wr_addr, done_addr;
    logic [511:0] wr_data;

    logic rnd_mode = 1'b0;
    logic d_idle = 1'b0, d_ready = 1'b0, d_pop = 1'b0;
    logic r_idle = 1'b0, r_ready = 1'b0, r_pop = 1'b0;
    assign mc_idle  = rnd_mode ? r_idle  : d_idle;
    assign wr_ready = rnd_mode ? r_ready : d_ready;
    assign done_pop = rnd_mode ? r_pop   : d_pop;

    zero_sweeper uut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_base(push_base),
        .push_pages(push_pages), .push_size(push_size), .push_ok(push_ok),
        .push_rej_full(push_rej_full), .push_rej_bad(push_rej_bad),
        .mc_idle(mc_idle), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_nocache(wr_nocache), .wr_ready(wr_ready),
        .done_valid(done_valid), .done_addr(done_addr), .done_pop(done_pop),
        .busy(busy)
    );

    int n_chk = 0, n_bad = 0, n_ok = 0, n_full = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [31:0] bytes_of(input logic [1:0] s);
        return 32'd4096 << (2 * s);
    endfunction

    // reference model
    range_t      mq[$];
    int          m_line = 0, m_page = 0;
    logic [31:0] exp_done[$];

    logic        p_push = 0, p_wv = 0, p_wr = 0, p_idle = 0, p_pop = 0, p_dv = 0;
    logic [31:0] p_pbase = 0, p_addr = 0;
    logic [7:0]  p_ppages = 0;
    logic [1:0]  p_psize = 0;
    int          p_cnt = 0;

    always @(posedge clk) begin
        #2;
        r_idle  = ($urandom % 10) < 7;
        r_ready = ($urandom % 10) < 6;
        r_pop   = ($urandom % 2) == 1;
    end

    always @(negedge clk) begin
        if (rst) begin
            p_push = 0; p_wv = 0; p_wr = 0; p_pop = 0; p_dv = 0; p_cnt = 0;
        end else begin
            // events of the edge just passed
            if (p_push) begin
                if (((p_pbase & (bytes_of(p_psize) - 1)) != 0) || p_ppages == 0)
                    chk(push_rej_bad && !push_ok && !push_rej_full, "R3 bad push response",
                        {push_ok, push_rej_full, push_rej_bad}, 3'b001);
                else
                    chk((push_ok ^ push_rej_full) && !push_rej_bad, "R2 good push response",
                        {push_ok, push_rej_full, push_rej_bad}, 3'b100);
                if (push_ok) begin
                    mq.push_back('{base: p_pbase, pages: p_ppages, sel: p_psize});
                    n_ok++;
                end
                if (push_rej_full) n_full++;
            end else begin
                chk(!push_ok && !push_rej_full && !push_rej_bad, "R3 no push no response",
                    {push_ok, push_rej_full, push_rej_bad}, 0);
            end
            if (p_wv && p_wr) begin
                if (mq.size() == 0) begin
                    chk(0, "R7 unexpected write", p_addr, 0);
                end else begin
                    logic [31:0] pb, ex;
                    pb = mq[0].base + m_page * bytes_of(mq[0].sel);
                    ex = pb + m_line * 64;
                    chk(p_addr == ex, "R7 write address", p_addr, ex);
                    m_line++;
                    if (m_line == int'(bytes_of(mq[0].sel) / 64)) begin
                        exp_done.push_back(pb);
                        m_line = 0;
                        m_page++;
                        if (m_page == int'(mq[0].pages)) begin
                            void'(mq.pop_front());
                            m_page = 0;
                        end
                    end
                end
            end
            if (p_pop && p_dv && exp_done.size() > 0) void'(exp_done.pop_front());

            // present-state checks
            chk(done_valid == (exp_done.size() > 0), "R8 done_valid", done_valid, exp_done.size() > 0);
            if (done_valid && exp_done.size() > 0)
                chk(done_addr == exp_done[0], "R8 done_addr", done_addr, exp_done[0]);
            chk(busy == (mq.size() > 0), "R10 busy", busy, mq.size() > 0);
            if (wr_valid)
                chk(wr_nocache && wr_data == '0, "R11 zero uncached write", {63'd0, wr_nocache}, 1);
            if (wr_valid && !p_wv) begin
                chk(p_idle, "R5 write rose without idle", p_idle, 1);
                chk(p_cnt < 8, "R9 write rose with full completions", p_cnt, 7);
            end
            if (p_wv && !p_wr)
                chk(wr_valid && wr_addr == p_addr, "R6 held write", {wr_valid, wr_addr}, {1'b1, p_addr});
        end
        p_push = push_valid; p_pbase = push_base; p_ppages = push_pages; p_psize = push_size;
        p_wv = wr_valid; p_wr = wr_ready; p_addr = wr_addr; p_idle = mc_idle;
        p_pop = done_pop; p_dv = done_valid; p_cnt = exp_done.size();
    end

    task automatic do_push(input logic [31:0] b, input logic [7:0] n, input logic [1:0] s);
        push_valid = 1; push_base = b; push_pages = n; push_size = s;
        @(posedge clk); #2;
        push_valid = 0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic drain();
        int lim;
        rnd_mode = 0; d_idle = 1; d_ready = 1; d_pop = 1;
        lim = 0;
        while ((busy || done_valid) && lim < 60000) begin
            @(posedge clk); #2;
            lim++;
        end
        chk(lim < 60000, "R10 drain completes", lim, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        int ok0, full0, lim;
        void'($urandom(32'd2024));
        cycles(5);
        rst = 0;
        cycles(1);
        @(negedge clk);
        chk(!wr_valid && !done_valid && !busy && !push_ok && !push_rej_full && !push_rej_bad,
            "R1 reset state", {wr_valid, done_valid, busy, push_ok, push_rej_full, push_rej_bad}, 0);
        @(posedge clk); #2;

        // R3: misaligned, zero count, size-dependent alignment
        do_push(32'h1000_0800, 8'd1, 2'd0);
        do_push(32'h1000_0000, 8'd0, 2'd0);
        do_push(32'h1000_1000, 8'd1, 2'd1);
        cycles(3);
        chk(!busy, "R3 rejected push leaves no work", busy, 0);

        // R4: fill the list while idle is low
        ok0 = n_ok; full0 = n_full;
        d_idle = 0;
        for (int i = 0; i < 10; i++) do_push(32'h2000_0000 + i * 32'h1000, 8'd1, 2'd0);
        cycles(3);
        chk(n_ok - ok0 == 9, "R4 accepted count", n_ok - ok0, 9);
        chk(n_full - full0 == 1, "R4 rejected-full count", n_full - full0, 1);
        cycles(20);
        chk(!wr_valid, "R5 no write while idle low", wr_valid, 0);
        drain();

        // R6: write held while idle drops
        d_ready = 0; d_idle = 1;
        do_push(32'h2100_0000, 8'd1, 2'd0);
        lim = 0;
        while (!wr_valid && lim < 20) begin cycles(1); lim++; end
        d_idle = 0;
        cycles(5);
        chk(wr_valid && wr_addr == 32'h2100_0000, "R6 write still presented", wr_addr, 32'h2100_0000);
        d_ready = 1;
        cycles(6);
        chk(!wr_valid, "R5 no new write after accept with idle low", wr_valid, 0);
        drain();

        // R9: completion queue fills, zeroing stalls
        d_pop = 0; d_idle = 1; d_ready = 1;
        do_push(32'h3000_0000, 8'd10, 2'd0);
        lim = 0;
        while (exp_done.size() < 8 && lim < 5000) begin cycles(1); lim++; end
        cycles(10);
        chk(!wr_valid && busy, "R9 stalled on full completions", {wr_valid, busy}, 2'b01);
        chk(exp_done.size() == 8, "R9 eight completions", exp_done.size(), 8);
        drain();

        // R7: larger sizes, size latched per request
        do_push(32'h4000_0000, 8'd1, 2'd2);
        do_push(32'h4004_0000, 8'd1, 2'd3);
        do_push(32'h4010_4000, 8'd2, 2'd1);
        drain();

        // constrained random phase
        rnd_mode = 1;
        for (int i = 0; i < 30; i++) begin
            logic [1:0]  s;
            logic [31:0] b;
            logic [7:0]  n;
            s = 2'($urandom % 2);
            b = (($urandom & 32'h0FFF_FFFF) | 32'h1000_0000) & ~(bytes_of(s) - 1);
            if ($urandom % 8 == 0) b = b | 32'h40;
            n = 8'(1 + $urandom % 3);
            if ($urandom % 20 == 0) n = 0;
            do_push(b, n, s);
            cycles(int'($urandom % 40));
        end
        drain();
        cycles(3);
        chk(!busy && mq.size() == 0 && exp_done.size() == 0, "R10 idle at end",
            {busy, 31'(mq.size())}, 0);
        summary();
    end
endmodule